// File: doc/BRIEF.md
# Doorbell Trigger and Cause Unit

This unit collects software-generated inter-processor messages and PCI message-signalled interrupts into per-CPU doorbell cause registers. A single trigger port accepts a write word. That word names one of 32 doorbells and a set of target CPUs. The unit latches the doorbell into the cause register of every targeted CPU. A PCIe MSI write lands on the same trigger port. Its data word names doorbell n+16 and targets all four CPUs.

Each CPU also has a mask register, and both of its registers sit on a shared register write port. Writing the cause register works as write-zero-to-clear: bits written as 0 are cleared and bits written as 1 are kept. From the cause and mask bits, each CPU gets two summary lines. The message line covers doorbells 0 to 7 and feeds per-CPU source 0 of the main controller. The MSI line covers doorbells 16 to 31 and feeds per-CPU source 1.

The asynchronous active-low reset is released through a two-stage synchronizer. The first edge at which register updates take effect is therefore the third rising edge after `rst_n` goes high.

Top module: `db_doorbell_unit`

## Requirements
- R1: After reset, every cause bit, every mask bit and every summary line is 0.
- R2: When `trig_en` is high, doorbell number `trig_data[4:0]` is set in the cause register of each CPU c for which `trig_data[8+c]` is 1. The cause bit is visible on `cause_q` after the next rising edge. CPUs whose target bit is 0 are unchanged, and `trig_data[7:5]` and `trig_data[31:12]` have no effect.
- R3: A register write with `wr_addr` = 4'h8 to CPU `wr_cpu` replaces that CPU's cause with cause AND `wr_data`. Writing all zeros clears every pending doorbell.
- R4: If a trigger sets a bit in the same cycle that a cause write clears it, the bit ends up set.
- R5: A register write with `wr_addr` = 4'hC replaces the mask register of CPU `wr_cpu` with `wr_data`.
- R6: For each CPU, `ipi_irq[c]` is the OR over doorbells 0 to 7 of cause AND mask.
- R7: For each CPU, `msi_irq[c]` is the OR over doorbells 16 to 31 of cause AND mask.
- R8: Doorbells 8 to 15 latch in the cause register but drive neither summary line.
- R9: A trigger word of 12'hF00 | (n+16), for n from 0 to 15, sets doorbell n+16 in all four CPUs.
- R10: Register writes to any `wr_addr` other than 4'h8 and 4'hC change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_en | input | 1 | Trigger write strobe |
| trig_data | input | 32 | Trigger word: doorbell number [4:0], CPU target mask [11:8] |
| wr_en | input | 1 | Per-CPU register write strobe |
| wr_cpu | input | 2 | CPU whose registers are written |
| wr_addr | input | 4 | Register offset: 4'h8 cause, 4'hC mask |
| wr_data | input | 32 | Register write data |
| cause_q | output | 128 | Cause registers, CPU c at bits [32c+31:32c] |
| mask_q | output | 128 | Mask registers, CPU c at bits [32c+31:32c] |
| ipi_irq | output | 4 | Per-CPU message summary (doorbells 0 to 7) |
| msi_irq | output | 4 | Per-CPU MSI summary (doorbells 16 to 31) |

## Verification
Two operations can land on the same cause bit in one cycle: a trigger setting it and a write-zero-to-clear of that CPU's cause. The bench drives both in one cycle, aiming the trigger at a bit that the write data clears. It expects the bit to survive while the other cleared bits drop. A long stretch of random traffic then mixes triggers and register writes freely. On every clock, a behavioural model that applies the clear and then the set judges all outputs.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int unsigned DB_TRIG_W    = 32;
  localparam int unsigned DB_ADDR_W    = 4;
  localparam int unsigned DB_TGT_LSB   = 8;
  localparam logic [3:0]  DB_OFS_CAUSE = 4'h8;
  localparam logic [3:0]  DB_OFS_MASK  = 4'hC;
  localparam int unsigned DB_MSG_LO    = 0;
  localparam int unsigned DB_MSG_HI    = 7;
  localparam int unsigned DB_MSI_LO    = 16;
  localparam int unsigned DB_MSI_HI    = 31;

  typedef enum logic [1:0] {
    REG_NONE  = 2'd0,
    REG_CAUSE = 2'd1,
    REG_MASK  = 2'd2
  } db_reg_e;
endpackage

// File: rtl/db_rst_sync.sv
module db_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/db_trig_decode.sv
module db_trig_decode #(
  parameter int unsigned NCPU = 4,
  parameter int unsigned NDB  = 32
) (
  input  logic                           trig_en,
  input  logic [db_pkg::DB_TRIG_W-1:0]   trig_data,
  output logic [NCPU-1:0][NDB-1:0]       set_vec
);
  localparam int unsigned NUM_W = $clog2(NDB);

  logic [NUM_W-1:0] db_num;
  logic [NCPU-1:0]  tgt;
  logic [NDB-1:0]   onehot;

  assign db_num = trig_data[NUM_W-1:0];
  assign tgt    = trig_data[db_pkg::DB_TGT_LSB +: NCPU];
  assign onehot = {{(NDB-1){1'b0}}, 1'b1} << db_num;

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    assign set_vec[g] = (trig_en && tgt[g]) ? onehot : '0;

    always_comb begin
      assert_single_bit_R2: assert ($onehot0(set_vec[g]))
        else $error("trigger decode set more than one doorbell");
    end
  end
endmodule

// File: rtl/db_cpu_bank.sv
module db_cpu_bank #(
  parameter int unsigned NDB = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NDB-1:0]                set_vec,
  input  logic                          wr_en,
  input  logic [db_pkg::DB_ADDR_W-1:0]  wr_addr,
  input  logic [NDB-1:0]                wr_data,
  output logic [NDB-1:0]                cause_q,
  output logic [NDB-1:0]                mask_q,
  output logic                          ipi_irq,
  output logic                          msi_irq
);
  import db_pkg::*;

  function automatic logic [NDB-1:0] range_sel(int unsigned lo, int unsigned hi);
    logic [NDB-1:0] r;
    r = '0;
    for (int i = 0; i < NDB; i++) r[i] = (i >= lo) && (i <= hi);
    return r;
  endfunction

  localparam logic [NDB-1:0] MSG_SEL = range_sel(DB_MSG_LO, DB_MSG_HI);
  localparam logic [NDB-1:0] MSI_SEL = range_sel(DB_MSI_LO, DB_MSI_HI);

  db_reg_e        reg_sel;
  logic           cause_en, mask_en;
  logic [NDB-1:0] cause_d, mask_d, pend;

  always_comb begin
    reg_sel = REG_NONE;
    if (wr_en && wr_addr == DB_OFS_CAUSE) reg_sel = REG_CAUSE;
    if (wr_en && wr_addr == DB_OFS_MASK)  reg_sel = REG_MASK;
  end

  always_comb begin
    cause_en = (reg_sel == REG_CAUSE) || (|set_vec);
    cause_d  = ((reg_sel == REG_CAUSE) ? (cause_q & wr_data) : cause_q) | set_vec;
    mask_en  = (reg_sel == REG_MASK);
    mask_d   = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      if (cause_en) cause_q <= cause_d;
      if (mask_en)  mask_q  <= mask_d;
    end
  end

  assign pend    = cause_q & mask_q;
  assign ipi_irq = |(pend & MSG_SEL);
  assign msi_irq = |(pend & MSI_SEL);

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((cause_q & $past(set_vec)) == $past(set_vec)));

  assert_clear_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == DB_OFS_CAUSE && set_vec == '0)
      |=> (cause_q == ($past(cause_q) & $past(wr_data))));

  assert_cause_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && !(wr_en && wr_addr == DB_OFS_CAUSE)) |=> $stable(cause_q));

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == DB_OFS_MASK) |=> $stable(mask_q));

  assert_msg_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & MSG_SEL) == '0) |-> !ipi_irq);

  assert_msi_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q & MSI_SEL) == '0) |-> !msi_irq);
endmodule

// File: rtl/db_doorbell_unit.sv
module db_doorbell_unit #(
  parameter int unsigned NCPU = 4,
  parameter int unsigned NDB  = 32,
  localparam int unsigned CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          trig_en,
  input  logic [db_pkg::DB_TRIG_W-1:0]  trig_data,
  input  logic                          wr_en,
  input  logic [CPU_W-1:0]              wr_cpu,
  input  logic [db_pkg::DB_ADDR_W-1:0]  wr_addr,
  input  logic [NDB-1:0]                wr_data,
  output logic [NCPU*NDB-1:0]           cause_q,
  output logic [NCPU*NDB-1:0]           mask_q,
  output logic [NCPU-1:0]               ipi_irq,
  output logic [NCPU-1:0]               msi_irq
);
  logic                     rst_sync_n;
  logic [NCPU-1:0][NDB-1:0] set_vec;

  db_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  db_trig_decode #(.NCPU(NCPU), .NDB(NDB)) u_dec (
    .trig_en   (trig_en),
    .trig_data (trig_data),
    .set_vec   (set_vec)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en && (wr_cpu == CPU_W'(c));

    db_cpu_bank #(.NDB(NDB)) u_bank (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .set_vec (set_vec[c]),
      .wr_en   (bank_we),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .cause_q (cause_q[c*NDB +: NDB]),
      .mask_q  (mask_q[c*NDB +: NDB]),
      .ipi_irq (ipi_irq[c]),
      .msi_irq (msi_irq[c])
    );
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_sync_n |=> (cause_q == '0 && mask_q == '0));
endmodule

// File: tb/db_doorbell_unit_test.sv
`timescale 1ns/1ps
module db_doorbell_unit_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         trig_en;
  logic [31:0]  trig_data;
  logic         wr_en;
  logic [1:0]   wr_cpu;
  logic [3:0]   wr_addr;
  logic [31:0]  wr_data;
  logic [127:0] cause_q, mask_q;
  logic [3:0]   ipi_irq, msi_irq;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  logic [31:0] m_cause [4];
  logic [31:0] m_mask  [4];

  always #2 clk = ~clk;

  db_doorbell_unit uut (
    .clk(clk), .rst_n(rst_n), .trig_en(trig_en), .trig_data(trig_data),
    .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_addr(wr_addr), .wr_data(wr_data),
    .cause_q(cause_q), .mask_q(mask_q), .ipi_irq(ipi_irq), .msi_irq(msi_irq)
  );

  task automatic compare(input string tag);
    for (int c = 0; c < 4; c++) begin
      logic [31:0] p;
      logic ei, em;
      p  = m_cause[c] & m_mask[c];
      ei = |p[7:0];
      em = |p[31:16];
      vectors++;
      if (cause_q[c*32 +: 32] !== m_cause[c]) begin
        errors++;
        $display("FAIL %s cpu%0d cause got %h exp %h", tag, c, cause_q[c*32 +: 32], m_cause[c]);
      end
      if (mask_q[c*32 +: 32] !== m_mask[c]) begin
        errors++;
        $display("FAIL %s cpu%0d mask got %h exp %h", tag, c, mask_q[c*32 +: 32], m_mask[c]);
      end
      if (ipi_irq[c] !== ei) begin
        errors++;
        $display("FAIL %s/R6 cpu%0d ipi_irq got %b exp %b", tag, c, ipi_irq[c], ei);
      end
      if (msi_irq[c] !== em) begin
        errors++;
        $display("FAIL %s/R7 cpu%0d msi_irq got %b exp %b", tag, c, msi_irq[c], em);
      end
    end
  endtask

  task automatic idle_inputs();
    trig_en = 0; trig_data = '0; wr_en = 0; wr_cpu = '0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic step(input bit te, input logic [31:0] td, input bit we,
                      input logic [1:0] wc, input logic [3:0] wa,
                      input logic [31:0] wd, input string tag);
    trig_en = te; trig_data = td; wr_en = we; wr_cpu = wc; wr_addr = wa; wr_data = wd;
    for (int c = 0; c < 4; c++) begin
      if (we && wc == 2'(c) && wa == 4'h8) m_cause[c] = m_cause[c] & wd;
      if (we && wc == 2'(c) && wa == 4'hC) m_mask[c]  = wd;
      if (te && td[8+c]) m_cause[c] = m_cause[c] | (32'd1 << td[4:0]);
    end
    @(posedge clk);
    #1;
    idle_inputs();
    compare(tag);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin m_cause[c] = '0; m_mask[c] = '0; end
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1 compare("R1");

    // R2: doorbell 3 to cpu0 and cpu2, upper junk bits ignored
    step(1, 32'hABCD_F5E3 & 32'hFFFF_F5E3, 0, 0, 0, 0, "R2");
    step(1, 32'h0000_0A03, 0, 0, 0, 0, "R2");
    // R5/R6: unmask message range on cpu0 and cpu2
    step(0, 0, 1, 2'd0, 4'hC, 32'h0000_00FF, "R5");
    step(0, 0, 1, 2'd2, 4'hC, 32'h0000_0008, "R6");
    // R9/R7: MSI vectors
    step(0, 0, 1, 2'd1, 4'hC, 32'hFFFF_0000, "R5");
    for (int n = 0; n < 16; n++) step(1, 32'hF00 | (n + 16), 0, 0, 0, 0, "R9");
    // R8: doorbells 8..15 latched, no summary
    step(0, 0, 1, 2'd3, 4'hC, 32'h0000_FF00, "R8");
    for (int n = 8; n < 16; n++) step(1, 32'h800 | n, 0, 0, 0, 0, "R8");
    // R3: write-zero-to-clear
    step(0, 0, 1, 2'd1, 4'h8, 32'h5555_FFFF, "R3");
    step(0, 0, 1, 2'd1, 4'h8, 32'h0000_0000, "R3");
    // R4: set and clear of the same bit in one cycle
    step(0, 0, 1, 2'd0, 4'h8, 32'hFFFF_FFFF, "R4");
    step(1, 32'h0000_0113, 1, 2'd0, 4'h8, 32'h0000_0000, "R4");
    step(1, 32'h0000_0F05, 1, 2'd2, 4'h8, 32'h0000_0000, "R4");
    // R10: other offsets ignored
    step(0, 0, 1, 2'd0, 4'h0, 32'h0000_0000, "R10");
    step(0, 0, 1, 2'd0, 4'h4, 32'hFFFF_FFFF, "R10");
    step(0, 0, 1, 2'd3, 4'hF, 32'h0000_0000, "R10");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r1, r2;
      r1 = $urandom; r2 = $urandom;
      step(r1[0], {20'h0, r1[11:8], 3'b0, r1[20:16]}, r1[1], r1[3:2],
           r1[4] ? 4'h8 : (r1[5] ? 4'hC : r1[27:24]), r2, "RND");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule